// File: doc/BRIEF.md
# Subroutine Return-Address Stack

This block holds the return addresses of a micro-programmed controller's subroutine calls so that calls can be nested. When the sequencer runs a call micro-code, the micro-PC already contains the address of the instruction after the call. The block stores that value on top of a last-in first-out stack. When the sequencer runs a return micro-code, it takes the top entry from the return-address output as its next program address. In the same clock edge the block removes that entry.

The default build holds four 10-bit entries. That covers four levels of nesting on a 1024-word program memory. The write position always sits one above the current top, and the read position always selects the current top. A single level counter drives both positions. Illegal requests raise a flag and leave the stack untouched: a return with nothing stacked, a call with all entries in use, or both strobes at once. The flag stays high until the next reset. The asynchronous reset is released to the logic in step with the clock.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is applied, and after it, the stack is empty, `ret_addr_o` is 0 and `err_o` is 0. The internal reset is released on the second rising clock edge after `rst_n` goes high, and strobes are honoured from the edge after that.
- R2: A call (`call_i`=1, `ret_i`=0) on a stack that is not full stores `pc_i`. From the next cycle, `ret_addr_o` equals the stored value.
- R3: Up to four calls nest. Returns then present the stored addresses in the reverse order of the calls.
- R4: A return (`ret_i`=1, `call_i`=0) on a non-empty stack removes the top entry. From the next cycle, `ret_addr_o` shows the entry beneath it, or 0 if none remains.
- R5: `ret_addr_o` is 0 whenever the stack holds no entry.
- R6: A return on an empty stack sets `err_o` from the next cycle and leaves the stack unchanged.
- R7: A call while four entries are held sets `err_o` from the next cycle. The stack keeps its four entries and the output is unchanged.
- R8: A call and a return in the same cycle set `err_o` from the next cycle and leave the stack unchanged.
- R9: Once set, `err_o` stays 1 until reset. Legal calls and returns after an error still work normally.
- R10: In a cycle with neither strobe, the stack contents and `ret_addr_o` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe: store `pc_i` on top of the stack |
| ret_i | input | 1 | Return strobe: remove the top entry |
| pc_i | input | 10 | Micro-PC value, the address following the call |
| ret_addr_o | output | 10 | Current top entry, or 0 when empty |
| err_o | output | 1 | Sticky underflow/overflow/conflict flag |

## Verification
The hardest condition to reach is a rejected fifth call. For it to prove anything, the bench must show afterwards that all four stored addresses survive intact. The stimulus therefore fills the stack with four distinct addresses and issues the extra call. It then unwinds with four returns, comparing each output against a queue model, and a final return drives the stack into underflow. A long random stretch then mixes calls, returns and conflicting strobes at every fill level. An asynchronous reset arrives while entries are held, which checks that clearing takes effect without waiting for a clock edge.

// File: rtl/rastk_pkg.sv
package rastk_pkg;
  // Decoded action for one clock cycle.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_FAULT = 2'd3
  } op_e;
endpackage

// File: rtl/rastk_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module rastk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rastk_ctl.sv
// Level counter, request decode and sticky error flag.
module rastk_ctl
  import rastk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  output op_e           op_o,
  output logic [LW-1:0] level_o,
  output logic          err_o
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_ONE  = LW'(1);

  logic [LW-1:0] level_q, level_d;
  logic          level_en;
  logic          err_q, err_d;
  logic          full, empty;
  op_e           op;

  assign full  = (level_q == LVL_FULL);
  assign empty = (level_q == '0);

  always_comb begin
    unique case ({call_i, ret_i})
      2'b10:   op = full  ? OP_FAULT : OP_PUSH;
      2'b01:   op = empty ? OP_FAULT : OP_POP;
      2'b11:   op = OP_FAULT;
      default: op = OP_IDLE;
    endcase
  end

  always_comb begin
    level_en = 1'b0;
    level_d  = level_q;
    unique case (op)
      OP_PUSH: begin
        level_en = 1'b1;
        level_d  = level_q + LVL_ONE;
      end
      OP_POP: begin
        level_en = 1'b1;
        level_d  = level_q - LVL_ONE;
      end
      default: ;
    endcase
    err_d = err_q | (op == OP_FAULT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       level_q <= '0;
    else if (level_en) level_q <= level_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign op_o    = op;
  assign level_o = level_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rastk_bank.sv
// Entry registers with write-select decode and top-of-stack read mux.
module rastk_bank #(
  parameter int AW    = 10,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] pc_i,
  input  logic [LW-1:0] level_i,
  output logic [AW-1:0] top_o
);
  logic [AW-1:0]    entry_q [DEPTH];
  logic [DEPTH-1:0] wr_sel;
  logic [DEPTH-1:0] rd_sel;

  // Write position: slot index equal to the level (one above the top).
  // Read position: slot index equal to the level minus one (the top).
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_sel[i] = push_i && (level_i == LW'(i));
    assign rd_sel[i] = (level_i == LW'(i + 1));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)        entry_q[i] <= '0;
      else if (wr_sel[i]) entry_q[i] <= pc_i;
    end
  end

  // At most one read select is active; none when empty, giving 0.
  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_sel[i]) top_o = entry_q[i];
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rastk_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          err_o
);
  logic          rst_sync_n;
  op_e           op;
  logic [LW-1:0] level;
  logic          push;

  rastk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rastk_ctl #(.DEPTH(DEPTH), .LW(LW)) u_ctl (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .op_o    (op),
    .level_o (level),
    .err_o   (err_o)
  );

  assign push = (op == OP_PUSH);

  rastk_bank #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_bank (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .push_i  (push),
    .pc_i    (pc_i),
    .level_i (level),
    .top_o   (ret_addr_o)
  );
endmodule

// File: rtl/rastk_chk.sv
module rastk_chk #(
  parameter int AW    = 10,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          call_i,
  input logic          ret_i,
  input logic [AW-1:0] pc_i,
  input logic [LW-1:0] level,
  input logic [AW-1:0] ret_addr_o,
  input logic          err_o
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  // R2
  p_push_shows_pc_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (call_i && !ret_i && level != LVL_FULL) |=> (ret_addr_o == $past(pc_i)));

  // R4
  p_pop_drops_one_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ret_i && !call_i && level != '0) |=> (level == $past(level) - LW'(1)));

  // R5
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (level == '0) |-> (ret_addr_o == '0));

  // R6
  p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ret_i && !call_i && level == '0) |=> (err_o && level == '0));

  // R7
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (call_i && !ret_i && level == LVL_FULL) |=> (err_o && $stable(level) && $stable(ret_addr_o)));

  // R8
  p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (call_i && ret_i) |=> (err_o && $stable(level) && $stable(ret_addr_o)));

  // R9
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    err_o |=> err_o);

  // R10
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!call_i && !ret_i) |=> ($stable(level) && $stable(ret_addr_o)));

  // R3
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    level <= LVL_FULL);
endmodule

bind ret_addr_stack rastk_chk #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .pc_i       (pc_i),
  .level      (level),
  .ret_addr_o (ret_addr_o),
  .err_o      (err_o)
);

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
  localparam int AW = 10;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 1'b0;
  logic          ret_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] ret_addr_o;
  logic          err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mstk[$];
  bit merr = 0;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.AW(AW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .pc_i(pc_i), .ret_addr_o(ret_addr_o), .err_o(err_o)
  );

  function automatic int exp_top();
    return (mstk.size() > 0) ? mstk[mstk.size()-1] : 0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (ret_addr_o !== AW'(exp_top())) begin
      errors++;
      $display("FAIL %s ret_addr_o actual=%0d expected=%0d", tag, ret_addr_o, exp_top());
    end
    checks++;
    if (err_o !== merr) begin
      errors++;
      $display("FAIL %s err_o actual=%0b expected=%0b", tag, err_o, merr);
    end
  endtask

  // Drive one cycle, advance the model at the edge, compare 2 ns later.
  task automatic step(bit c, bit r, int pc, string tag);
    call_i = c; ret_i = r; pc_i = AW'(pc);
    @(posedge clk);
    if (c && !r && mstk.size() < DEPTH) mstk.push_back(pc);
    else if (r && !c && mstk.size() > 0) void'(mstk.pop_back());
    else if (c || r) merr = 1;
    #2;
    compare(tag);
  endtask

  task automatic do_reset();
    call_i = 0; ret_i = 0;
    rst_n = 0;
    #1;
    mstk.delete(); merr = 0;
    compare("R1");                     // async clear
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);         // synchronizer release
    #2;
    compare("R1");
  endtask

  initial begin
    do_reset();
    // R2, R3: fill four levels
    step(1, 0, 100, "R2");
    step(1, 0, 257, "R3");
    step(0, 0, 999, "R10");
    step(1, 0, 512, "R3");
    step(1, 0, 1023, "R3");
    // R7: fifth call rejected, contents kept
    step(1, 0, 77, "R7");
    step(0, 0, 0, "R10");
    // R4: unwind in reverse
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R5");
    // R6: underflow
    step(0, 1, 0, "R6");
    // R9: flag stays, operations still work
    step(1, 0, 33, "R9");
    step(0, 1, 0, "R9");
    step(0, 0, 0, "R9");
    do_reset();
    // R8: simultaneous strobes
    step(1, 0, 444, "R2");
    step(1, 1, 555, "R8");
    step(0, 0, 0, "R8");
    // random mix across all levels
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      bit c = (sel < 4) || (sel == 9);
      bit r = (sel >= 4 && sel < 8) || (sel == 9);
      step(c, r, $urandom_range(0, 1023), "R3");
      if (i == 150) do_reset();
    end
    // R1: async reset with entries held
    do_reset();
    step(1, 0, 12, "R2");
    step(1, 0, 34, "R2");
    @(negedge clk); rst_n = 0; #1;
    mstk.delete(); merr = 0;
    compare("R1");
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);
    #2;
    compare("R1");
    step(0, 0, 0, "R5");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule